// File: doc/BRIEF.md
# Thermal Throttling State Machine

This block turns a stream of temperature samples into a thermal operating level. Each strobed sample is compared, as an unsigned number, against a set of programmable start and stop thresholds. The result, together with the sign of the change since the previous reading, moves a state machine through six levels: init, normal, first-level throttle, second-level warning, tripped and low-temperature compensation. The thresholds come in pairs, so a level is entered at one temperature and left at a lower one.

Moving up a level needs only the start threshold. Moving down needs the stop threshold and also a falling trend. The block drives a CPU performance-limit level, a voltage-lock request for cold operation, a one-cycle notify pulse, a one-cycle shutdown request and a sticky emergency flag. Limit actions fire once per entry into a level, and flags keep them from repeating. A separate interrupt input can force the level directly, and it outranks the sample when both arrive in the same cycle.

The sensor, the frequency scaling hardware and any software notification sit outside the block. All outputs are registered and change on the clock edge that takes the sample or the interrupt.

Top module: `thermal_gov`

## Requirements
- R1: After reset, state_o is 0 (init) and perf_limit_o, vlock_o, notify_o, shutdown_o, emergency_o and irq_rearm_o are 0. State codes: 0 init, 1 normal, 2 throttled, 3 warning, 4 tripped, 5 compensation. Limit codes: 0 none, 1 first level, 2 second level.
- R2: A sample taken in init pulses notify_o. It then picks the first match from this list: tripped if temp ≥ trip; compensation with vlock_o set if temp ≤ comp-on; warning if temp ≥ t2-on; throttled if temp ≥ t1-on; normal if temp ≤ t1-off. With no match the state stays init.
- R3: From normal, a sample with temp ≥ t1-on moves to throttled. Otherwise a sample with temp ≤ comp-on moves to compensation and sets vlock_o.
- R4: In normal, a sample at or below both t1-off and mem-off releases any limit (perf_limit_o becomes 0), pulses notify_o and pulses irq_rearm_o. A sample between those two thresholds does nothing.
- R5: In throttled, the first sample with temp ≥ t1-on while the first-level flag is clear sets perf_limit_o to 1, sets that flag, clears the second-level flag and pulses notify_o. Later samples in the same stay do not repeat the pulse.
- R6: Throttled returns to normal only when temp ≤ t1-off and temp is below the previous reading. A rising sample at that temperature leaves the state unchanged.
- R7: Warning is entered from throttled at temp ≥ t2-on. Its first qualifying sample (temp ≥ t2-on, second-level flag clear) sets perf_limit_o to 2 once and pulses notify_o. Warning moves to tripped at temp ≥ trip, and back to throttled at temp ≤ t2-off with a falling trend.
- R8: In tripped, one sample with temp ≥ trip and a rising trend pulses shutdown_o and notify_o together, and this happens once. Tripped returns to warning at temp ≤ t2-off with a falling trend.
- R9: emergency_o sets on any sample with temp ≥ emerg and a rising trend, whatever the state, and stays set until reset.
- R10: From warning or tripped, a sample with temp ≤ comp-on moves to compensation with vlock_o set. In compensation, a sample releases any held limit. A sample with temp ≥ comp-off clears vlock_o and moves to normal.
- R11: An interrupt (irq_vld_i high with a nonzero irq_src_i) forces the state by priority: bit 3 (falling) gives compensation, bit 2 gives tripped, bit 1 gives warning, bit 0 gives throttled. A sample in the same cycle is ignored.
- R12: Without sample_vld_i, and without an interrupt that has a nonzero source, the state and the limit and lock outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Sample strobe |
| temp_i | input | TW | Temperature sample, unsigned |
| thr_t1_on_i | input | TW | First-level start threshold |
| thr_t1_off_i | input | TW | First-level stop threshold |
| thr_t2_on_i | input | TW | Second-level start threshold |
| thr_t2_off_i | input | TW | Second-level stop threshold |
| thr_trip_i | input | TW | Trip threshold |
| thr_emerg_i | input | TW | Emergency threshold |
| thr_comp_on_i | input | TW | Compensation start (cold) threshold |
| thr_comp_off_i | input | TW | Compensation stop threshold |
| thr_mem_off_i | input | TW | Memory-throttle stop threshold |
| irq_vld_i | input | 1 | Interrupt strobe |
| irq_src_i | input | 4 | Interrupt sources: bit0 rise0, bit1 rise1, bit2 rise2, bit3 falling |
| state_o | output | 3 | Current level code |
| perf_limit_o | output | 2 | CPU performance-limit level |
| vlock_o | output | 1 | Low-temperature voltage-lock request |
| notify_o | output | 1 | State-change notify pulse |
| shutdown_o | output | 1 | Shutdown request pulse |
| emergency_o | output | 1 | Sticky emergency flag |
| irq_rearm_o | output | 1 | Pulse to clear and re-enable interrupts |

## Verification
The assertions assume that the strobes and the interrupt source are held at 0 while reset is applied. They also assume the thresholds are static and ordered: comp-on below comp-off, below t1-off, below t1-on, below t2-off, below t2-on, below trip, below emerg. The stimulus sets each threshold once before reset is released and never changes it. It drives one strobe at a time, except for one deliberate cycle in which an interrupt and a sample coincide. Temperature sequences are chosen so that each trend-gated transition is tried with both a rising and a falling reading.

// File: rtl/thermal_gov_pkg.sv
package thermal_gov_pkg;
  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_NORM = 3'd1,
    ST_THR  = 3'd2,
    ST_WARN = 3'd3,
    ST_TRIP = 3'd4,
    ST_COMP = 3'd5
  } tstate_e;

  localparam int unsigned IRQ_SRCS = 4;
  localparam logic [1:0] LIM_NONE = 2'd0;
  localparam logic [1:0] LIM_L1   = 2'd1;
  localparam logic [1:0] LIM_L2   = 2'd2;

  typedef struct packed {
    logic ge_trip;
    logic ge_emerg;
    logic ge_t2;
    logic ge_t1;
    logic le_t2;
    logic le_t1;
    logic le_mem;
    logic le_comp;
    logic ge_cstop;
  } cmp_t;

  function automatic tstate_e irq_target(input int unsigned idx);
    case (idx)
      0:       return ST_THR;
      1:       return ST_WARN;
      2:       return ST_TRIP;
      default: return ST_COMP;
    endcase
  endfunction
endpackage

// File: rtl/thermal_cmp.sv
module thermal_cmp
  import thermal_gov_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] t1_on_i,
  input  logic [TW-1:0] t1_off_i,
  input  logic [TW-1:0] t2_on_i,
  input  logic [TW-1:0] t2_off_i,
  input  logic [TW-1:0] trip_i,
  input  logic [TW-1:0] emerg_i,
  input  logic [TW-1:0] comp_on_i,
  input  logic [TW-1:0] comp_off_i,
  input  logic [TW-1:0] mem_off_i,
  output cmp_t          cmp_o
);
  always_comb begin
    cmp_o.ge_trip  = temp_i >= trip_i;
    cmp_o.ge_emerg = temp_i >= emerg_i;
    cmp_o.ge_t2    = temp_i >= t2_on_i;
    cmp_o.ge_t1    = temp_i >= t1_on_i;
    cmp_o.le_t2    = temp_i <= t2_off_i;
    cmp_o.le_t1    = temp_i <= t1_off_i;
    cmp_o.le_mem   = temp_i <= mem_off_i;
    cmp_o.le_comp  = temp_i <= comp_on_i;
    cmp_o.ge_cstop = temp_i >= comp_off_i;
  end
endmodule

// File: rtl/thermal_trend.sv
module thermal_trend #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [TW-1:0] temp_i,
  output logic          rising_o,
  output logic          falling_o
);
  logic [TW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= '0;
    else if (upd_i) last_q <= temp_i;
  end

  assign rising_o  = temp_i > last_q;
  assign falling_o = temp_i < last_q;
endmodule

// File: rtl/thermal_irq_pick.sv
module thermal_irq_pick
  import thermal_gov_pkg::*;
(
  input  logic                vld_i,
  input  logic [IRQ_SRCS-1:0] src_i,
  output logic                evt_o,
  output tstate_e             st_o
);
  // higher index wins: falling > rise2 > rise1 > rise0
  always_comb begin
    st_o = ST_INIT;
    for (int unsigned i = 0; i < IRQ_SRCS; i++)
      if (src_i[i]) st_o = irq_target(i);
  end
  assign evt_o = vld_i && (|src_i);
endmodule

// File: rtl/thermal_fsm.sv
module thermal_fsm
  import thermal_gov_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic       irq_i,
  input  tstate_e    irq_st_i,
  input  cmp_t       cmp_i,
  input  logic       rising_i,
  input  logic       falling_i,
  output logic [2:0] state_o,
  output logic [1:0] perf_o,
  output logic       vlock_o,
  output logic       notify_o,
  output logic       shut_o,
  output logic       emerg_o,
  output logic       rearm_o
);
  tstate_e    st_q, st_n;
  logic [1:0] perf_q, perf_n;
  logic       vl_q, vl_n, em_q, em_n;
  logic       thr_q, thr_n, wrn_q, wrn_n, trp_q, trp_n;
  logic       nt_q, nt_n, sd_q, sd_n, rr_q, rr_n;

  always_comb begin
    st_n = st_q; perf_n = perf_q; vl_n = vl_q; em_n = em_q;
    thr_n = thr_q; wrn_n = wrn_q; trp_n = trp_q;
    nt_n = 1'b0; sd_n = 1'b0; rr_n = 1'b0;
    if (irq_i) begin
      st_n = irq_st_i;
    end else if (smp_i) begin
      if (cmp_i.ge_emerg && rising_i) em_n = 1'b1;
      case (st_q)
        ST_INIT: begin
          nt_n = 1'b1;
          if (cmp_i.ge_trip)      st_n = ST_TRIP;
          else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else if (cmp_i.ge_t2)   st_n = ST_WARN;
          else if (cmp_i.ge_t1)   st_n = ST_THR;
          else if (cmp_i.le_t1)   st_n = ST_NORM;
        end
        ST_NORM: begin
          if (cmp_i.ge_t1)        st_n = ST_THR;
          else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else if (cmp_i.le_t1 && cmp_i.le_mem) begin
            if (thr_q || wrn_q) begin
              perf_n = LIM_NONE; thr_n = 1'b0; wrn_n = 1'b0;
            end
            nt_n = 1'b1;
            rr_n = 1'b1;
          end
        end
        ST_THR: begin
          if (cmp_i.ge_t2)        st_n = ST_WARN;
          else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else if (cmp_i.ge_t1 && !thr_q) begin
            wrn_n = 1'b0; perf_n = LIM_L1; thr_n = 1'b1; nt_n = 1'b1;
          end else if (cmp_i.le_t1 && falling_i) st_n = ST_NORM;
        end
        ST_WARN: begin
          if (cmp_i.ge_trip)      st_n = ST_TRIP;
          else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else if (cmp_i.ge_t2 && !wrn_q) begin
            thr_n = 1'b0; perf_n = LIM_L2; wrn_n = 1'b1; nt_n = 1'b1;
          end else if (cmp_i.le_t2 && falling_i) st_n = ST_THR;
        end
        ST_TRIP: begin
          if (cmp_i.ge_trip && rising_i && !trp_q) begin
            nt_n = 1'b1; sd_n = 1'b1; trp_n = 1'b1;
          end else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else if (cmp_i.le_t2 && falling_i) st_n = ST_WARN;
        end
        ST_COMP: begin
          if (cmp_i.le_comp) vl_n = 1'b1;
          else if (cmp_i.ge_cstop) begin vl_n = 1'b0; st_n = ST_NORM; end
          if (thr_q || wrn_q || trp_q) begin
            perf_n = LIM_NONE; thr_n = 1'b0; wrn_n = 1'b0; trp_n = 1'b0;
          end
        end
        default: begin
          if (cmp_i.ge_trip)      st_n = ST_TRIP;
          else if (cmp_i.le_comp) begin st_n = ST_COMP; vl_n = 1'b1; end
          else                    st_n = ST_WARN;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_INIT; perf_q <= LIM_NONE; vl_q <= 1'b0; em_q <= 1'b0;
      thr_q <= 1'b0; wrn_q <= 1'b0; trp_q <= 1'b0;
      nt_q <= 1'b0; sd_q <= 1'b0; rr_q <= 1'b0;
    end else begin
      st_q <= st_n; perf_q <= perf_n; vl_q <= vl_n; em_q <= em_n;
      thr_q <= thr_n; wrn_q <= wrn_n; trp_q <= trp_n;
      nt_q <= nt_n; sd_q <= sd_n; rr_q <= rr_n;
    end
  end

  assign state_o  = st_q;
  assign perf_o   = perf_q;
  assign vlock_o  = vl_q;
  assign notify_o = nt_q;
  assign shut_o   = sd_q;
  assign emerg_o  = em_q;
  assign rearm_o  = rr_q;
endmodule

// File: rtl/thermal_gov.sv
module thermal_gov
  import thermal_gov_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_vld_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] thr_t1_on_i,
  input  logic [TW-1:0] thr_t1_off_i,
  input  logic [TW-1:0] thr_t2_on_i,
  input  logic [TW-1:0] thr_t2_off_i,
  input  logic [TW-1:0] thr_trip_i,
  input  logic [TW-1:0] thr_emerg_i,
  input  logic [TW-1:0] thr_comp_on_i,
  input  logic [TW-1:0] thr_comp_off_i,
  input  logic [TW-1:0] thr_mem_off_i,
  input  logic          irq_vld_i,
  input  logic [3:0]    irq_src_i,
  output logic [2:0]    state_o,
  output logic [1:0]    perf_limit_o,
  output logic          vlock_o,
  output logic          notify_o,
  output logic          shutdown_o,
  output logic          emergency_o,
  output logic          irq_rearm_o
);
  cmp_t    cmp;
  logic    rising, falling, irq_evt;
  tstate_e irq_st;

  thermal_cmp #(.TW(TW)) cmp_u (
    .temp_i(temp_i), .t1_on_i(thr_t1_on_i), .t1_off_i(thr_t1_off_i),
    .t2_on_i(thr_t2_on_i), .t2_off_i(thr_t2_off_i), .trip_i(thr_trip_i),
    .emerg_i(thr_emerg_i), .comp_on_i(thr_comp_on_i),
    .comp_off_i(thr_comp_off_i), .mem_off_i(thr_mem_off_i), .cmp_o(cmp)
  );

  thermal_irq_pick irq_u (
    .vld_i(irq_vld_i), .src_i(irq_src_i), .evt_o(irq_evt), .st_o(irq_st)
  );

  thermal_trend #(.TW(TW)) trend_u (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(sample_vld_i || irq_evt),
    .temp_i(temp_i), .rising_o(rising), .falling_o(falling)
  );

  thermal_fsm fsm_u (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(sample_vld_i), .irq_i(irq_evt),
    .irq_st_i(irq_st), .cmp_i(cmp), .rising_i(rising), .falling_i(falling),
    .state_o(state_o), .perf_o(perf_limit_o), .vlock_o(vlock_o),
    .notify_o(notify_o), .shut_o(shutdown_o), .emerg_o(emergency_o),
    .rearm_o(irq_rearm_o)
  );
endmodule

// File: rtl/thermal_gov_chk.sv
module thermal_gov_chk #(
  parameter int unsigned TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_vld_i,
  input logic [TW-1:0] temp_i,
  input logic [TW-1:0] thr_t1_on_i,
  input logic [TW-1:0] thr_t1_off_i,
  input logic [TW-1:0] thr_t2_on_i,
  input logic [TW-1:0] thr_t2_off_i,
  input logic [TW-1:0] thr_trip_i,
  input logic [TW-1:0] thr_emerg_i,
  input logic [TW-1:0] thr_comp_on_i,
  input logic [TW-1:0] thr_comp_off_i,
  input logic [TW-1:0] thr_mem_off_i,
  input logic          irq_vld_i,
  input logic [3:0]    irq_src_i,
  input logic [2:0]    state_o,
  input logic [1:0]    perf_limit_o,
  input logic          vlock_o,
  input logic          notify_o,
  input logic          shutdown_o,
  input logic          emergency_o,
  input logic          irq_rearm_o
);
  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_vld_i && !irq_vld_i) |=> ($stable(state_o) && $stable(perf_limit_o) && $stable(vlock_o)));

  p_irq_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vld_i && irq_src_i[3]) |=> (state_o == 3'd5));

  p_irq_rise2_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vld_i && irq_src_i[2] && !irq_src_i[3]) |=> (state_o == 3'd4));

  p_notify_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(sample_vld_i));

  p_shut_trip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (state_o == 3'd4 && notify_o));

  p_emerg_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emergency_o |=> emergency_o);

  p_vlock_comp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vlock_o) |-> (state_o == 3'd5));

  p_rearm_norm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rearm_o |-> (state_o == 3'd1 && notify_o && perf_limit_o == 2'd0));
endmodule

bind thermal_gov thermal_gov_chk #(.TW(TW)) chk_i (.*);

// File: tb/thermal_gov_tb_top.sv
module thermal_gov_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int NVEC = 35;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp = 1'b0, irq = 1'b0;
  logic [3:0] src = '0;
  logic [TW-1:0] temp = '0;
  logic [2:0] state;
  logic [1:0] perf;
  logic vlock, notify, shut, emerg, rearm;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_gov #(.TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(smp), .temp_i(temp),
    .thr_t1_on_i(8'd60), .thr_t1_off_i(8'd50), .thr_t2_on_i(8'd80),
    .thr_t2_off_i(8'd70), .thr_trip_i(8'd95), .thr_emerg_i(8'd110),
    .thr_comp_on_i(8'd10), .thr_comp_off_i(8'd15), .thr_mem_off_i(8'd45),
    .irq_vld_i(irq), .irq_src_i(src), .state_o(state), .perf_limit_o(perf),
    .vlock_o(vlock), .notify_o(notify), .shutdown_o(shut),
    .emergency_o(emerg), .irq_rearm_o(rearm)
  );

  typedef struct packed {
    logic       s; logic i; logic [3:0] src; logic [7:0] t;
    logic [2:0] st; logic [1:0] pf; logic vl; logic nt; logic sd; logic em; logic rr;
    logic [3:0] tag;
  } vec_t;

  // s i src temp | st pf vl nt sd em rr | tag
  localparam vec_t VEC [NVEC] = '{
    '{1,0,4'h0,8'd30, 3'd1,2'd0,0,1,0,0,0,4'd2},   // R2 init->normal
    '{1,0,4'h0,8'd55, 3'd1,2'd0,0,0,0,0,0,4'd3},   // R3
    '{1,0,4'h0,8'd48, 3'd1,2'd0,0,0,0,0,0,4'd4},   // R4 above mem-off
    '{1,0,4'h0,8'd40, 3'd1,2'd0,0,1,0,0,1,4'd4},   // R4 release
    '{1,0,4'h0,8'd65, 3'd2,2'd0,0,0,0,0,0,4'd3},   // R3
    '{1,0,4'h0,8'd66, 3'd2,2'd1,0,1,0,0,0,4'd5},   // R5 limit 1
    '{1,0,4'h0,8'd67, 3'd2,2'd1,0,0,0,0,0,4'd5},   // R5 no repeat
    '{1,0,4'h0,8'd45, 3'd1,2'd1,0,0,0,0,0,4'd6},   // R6 falling
    '{1,0,4'h0,8'd47, 3'd1,2'd1,0,0,0,0,0,4'd4},
    '{1,0,4'h0,8'd44, 3'd1,2'd0,0,1,0,0,1,4'd4},
    '{1,0,4'h0,8'd62, 3'd2,2'd0,0,0,0,0,0,4'd3},
    '{1,0,4'h0,8'd63, 3'd2,2'd1,0,1,0,0,0,4'd5},
    '{1,0,4'h0,8'd85, 3'd3,2'd1,0,0,0,0,0,4'd7},   // R7
    '{1,0,4'h0,8'd85, 3'd3,2'd2,0,1,0,0,0,4'd7},
    '{1,0,4'h0,8'd86, 3'd3,2'd2,0,0,0,0,0,4'd7},
    '{1,0,4'h0,8'd72, 3'd3,2'd2,0,0,0,0,0,4'd7},
    '{1,0,4'h0,8'd70, 3'd2,2'd2,0,0,0,0,0,4'd7},
    '{1,0,4'h0,8'd68, 3'd2,2'd1,0,1,0,0,0,4'd5},
    '{1,0,4'h0,8'd82, 3'd3,2'd1,0,0,0,0,0,4'd7},
    '{1,0,4'h0,8'd83, 3'd3,2'd2,0,1,0,0,0,4'd7},
    '{1,0,4'h0,8'd96, 3'd4,2'd2,0,0,0,0,0,4'd7},
    '{1,0,4'h0,8'd97, 3'd4,2'd2,0,1,1,0,0,4'd8},   // R8 shutdown
    '{1,0,4'h0,8'd98, 3'd4,2'd2,0,0,0,0,0,4'd8},
    '{1,0,4'h0,8'd112,3'd4,2'd2,0,0,0,1,0,4'd9},   // R9
    '{1,0,4'h0,8'd100,3'd4,2'd2,0,0,0,1,0,4'd9},
    '{1,0,4'h0,8'd69, 3'd3,2'd2,0,0,0,1,0,4'd8},
    '{1,0,4'h0,8'd8,  3'd5,2'd2,1,0,0,1,0,4'd10},  // R10
    '{1,0,4'h0,8'd12, 3'd5,2'd0,1,0,0,1,0,4'd10},
    '{1,0,4'h0,8'd16, 3'd1,2'd0,0,0,0,1,0,4'd10},
    '{1,0,4'h0,8'd5,  3'd5,2'd0,1,0,0,1,0,4'd10},
    '{0,1,4'h6,8'd20, 3'd4,2'd0,1,0,0,1,0,4'd11},  // R11
    '{0,1,4'h9,8'd20, 3'd5,2'd0,1,0,0,1,0,4'd11},
    '{0,1,4'h1,8'd20, 3'd2,2'd0,1,0,0,1,0,4'd11},
    '{1,1,4'h2,8'd5,  3'd3,2'd0,1,0,0,1,0,4'd11},
    '{1,0,4'h0,8'd5,  3'd5,2'd0,1,0,0,1,0,4'd10}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic i, input logic [3:0] sr, input logic [7:0] t);
    @(negedge clk);
    smp = s; irq = i; src = sr; temp = t;
    @(negedge clk);
    smp = 0; irq = 0; src = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic chk_all(input string tag, input int st, input int pf, input int vl,
                         input int nt, input int sd, input int em, input int rr);
    chk(tag, "state", state, st);
    chk(tag, "perf", perf, pf);
    chk(tag, "vlock", vlock, vl);
    chk(tag, "notify", notify, nt);
    chk(tag, "shutdown", shut, sd);
    chk(tag, "emergency", emerg, em);
    chk(tag, "rearm", rearm, rr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k].s, VEC[k].i, VEC[k].src, VEC[k].t);
      chk_all($sformatf("R%0d vec%0d", VEC[k].tag, k), VEC[k].st, VEC[k].pf, VEC[k].vl,
              VEC[k].nt, VEC[k].sd, VEC[k].em, VEC[k].rr);
    end

    // R12: idle cycles and an empty interrupt change nothing
    repeat (4) @(negedge clk);
    chk("R12", "state idle", state, 5);
    chk("R12", "vlock idle", vlock, 1);
    step(0, 1, 4'h0, 8'd90);
    chk("R12", "state empty irq", state, 5);

    // R1: reset mid-run clears everything including emergency
    do_reset();
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0);

    // R6: rising sample at/below t1-off keeps throttled
    step(0, 1, 4'h1, 8'd40);
    chk("R6", "forced thr", state, 2);
    step(1, 0, 4'h0, 8'd45);
    chk("R6", "no drop on rise", state, 2);

    // R2: init priority branches
    do_reset(); step(1, 0, 4'h0, 8'd96);
    chk("R2", "init trip", state, 4); chk("R2", "init notify", notify, 1);
    do_reset(); step(1, 0, 4'h0, 8'd9);
    chk("R2", "init comp", state, 5); chk("R2", "init vlock", vlock, 1);
    do_reset(); step(1, 0, 4'h0, 8'd81);
    chk("R2", "init warn", state, 3);
    do_reset(); step(1, 0, 4'h0, 8'd61);
    chk("R2", "init thr", state, 2);
    do_reset(); step(1, 0, 4'h0, 8'd55);
    chk("R2", "init hold", state, 0); chk("R2", "init hold notify", notify, 1);

    // R9: emergency straight from init on a rising sample
    do_reset(); step(1, 0, 4'h0, 8'd120);
    chk("R9", "emergency", emerg, 1);
    chk("R8", "trip from init", state, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule